// File: doc/BRIEF.md
# Walking Complement Memory Self-Test Engine

This block is a self-test engine for one single-port synchronous RAM. After a start pulse it takes over the RAM port. It visits every location in ascending order and writes each one with the bitwise inverse of its own index. One step behind that write pointer, it reads the location just below, compares the value with the inverse pattern, and then overwrites that location with its plain index. The top location is read back once more at the end. Because every location holds a value tied to its own address, address decoder faults and data faults both show up as mismatches.

A mismatch does not stop the walk. Each one increments a saturating error counter. The address, the expected word and the observed word of the first mismatch are kept for diagnosis. A skip input, or a target that is not marked read-write, ends the test at once with a done pulse and no RAM traffic. The RAM is assumed to return read data one cycle after the read is issued.

Top module: `wcomp_bist`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the engine idle: `busy`, `done`, `mem_en` and `fail_valid` are low, `err_count` is zero and `pass` is high.
- R2: A started walk issues exactly 3*DEPTH-1 RAM operations, one per cycle, in this order. For k = 0 up to DEPTH-1: write k. Then, if k>0: read k-1, followed by write k-1. Then, if k = DEPTH-1: read k.
- R3: The first write to location k carries the inverse of k, and the rewrite carries k itself. In both cases the index is first zero-extended (or truncated) to DW bits.
- R4: Each read is compared with the inverse pattern of its own address. The comparison uses `mem_rdata` in the cycle after the read is issued.
- R5: The top location is read and checked once after its own inverse write, as the last RAM operation of the walk.
- R6: Every mismatch increments `err_count`, which stops at 2^CW-1. The walk still completes all of its operations.
- R7: On the first mismatch of a test, `fail_valid` rises, and `fail_addr`, `fail_exp` and `fail_obs` capture the address, the expected word and the read word. Later mismatches leave these four outputs unchanged.
- R8: If `start` is accepted while `skip` is high or `target_rw` is low, `done` pulses in the next cycle, `busy` stays low and no RAM operation is issued.
- R9: A one-cycle `start` in idle raises `busy` in the next cycle. `busy` stays high for exactly 3*DEPTH cycles, then `done` is high for one cycle with `busy` low. A `start` seen while busy has no effect.
- R10: An accepted `start` clears `err_count` and the captured failure. `pass` is high exactly when `err_count` is zero.
- R11: Asserting reset in the middle of a walk returns the engine to idle, with no RAM traffic and the error state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a test |
| skip | input | 1 | When high at start, the test is skipped |
| target_rw | input | 1 | Target is read-write; when low at start, the test is skipped |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after a read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | High when the error count is zero |
| err_count | output | CW | Saturating mismatch count |
| fail_valid | output | 1 | A failure has been captured |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word of the first mismatch |
| fail_obs | output | DW | Observed word of the first mismatch |

## Verification
The hardest states to reach are a saturated error counter and a first-failure capture that later mismatches must not overwrite. A healthy RAM never gives a mismatch. The bench RAM model therefore carries a per-address mask that is XORed into read data only, so single, paired, top-location and all-location faults can be placed without touching the stored contents. The bench builds the engine with a narrow counter, so the all-location fault drives it into saturation well within one walk. A second start is also injected mid-walk, and a reset is applied after an error has been counted, to show that neither disturbs nor survives the walk.

// File: rtl/wcomp_bist_pkg.sv
package wcomp_bist_pkg;

   // Walk sequencer states; one RAM operation per access state
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_COMP,   // write inverse pattern at k
      ST_RD_PREV,   // read back k-1
      ST_WR_TRUE,   // rewrite k-1 with its plain index
      ST_RD_LAST,   // final read of the top location
      ST_DRAIN,     // wait for the last read data
      ST_FINISH     // done pulse
   } wcomp_state_e;

   // Kind of access issued in the current cycle
   typedef enum logic [1:0] {
      OP_NONE,
      OP_WRITE,
      OP_READ
   } wcomp_op_e;

endpackage

// File: rtl/wcomp_pattern.sv
// Maps an address to the inverse and plain data words of width DW.
module wcomp_pattern #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] inv_word,
   output logic [DW-1:0] plain_word
);

   logic [DW-1:0] fitted;

   generate
      if (DW > AW) begin : g_extend
         assign fitted = {{(DW-AW){1'b0}}, addr};
      end else if (DW == AW) begin : g_same
         assign fitted = addr;
      end else begin : g_trunc
         logic [AW-DW-1:0] dropped;
         assign fitted  = addr[DW-1:0];
         assign dropped = addr[AW-1:DW];
      end
   endgenerate

   assign plain_word = fitted;
   assign inv_word   = ~fitted;

endmodule

// File: rtl/wcomp_seq.sv
// Walk sequencer: address pointer, state machine and RAM command decode.
module wcomp_seq
   import wcomp_bist_pkg::*;
#(
   parameter int AW    = 4,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          skip,
   input  logic          target_rw,
   output logic          cmd_en,
   output logic          cmd_we,
   output logic [AW-1:0] cmd_addr,
   output logic          cmd_inv,
   output logic          rd_issue,
   output logic          clear,
   output logic          busy,
   output logic          done
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [AW-1:0] ONE  = AW'(1);

   wcomp_state_e  state_q, state_d;
   logic [AW-1:0] ptr_q, ptr_d;
   logic [AW-1:0] ptr_prev;
   logic          at_last;
   logic          at_first;
   wcomp_op_e     op;

   assign ptr_prev = ptr_q - ONE;
   assign at_last  = (ptr_q == LAST);
   assign at_first = (ptr_q == '0);

   always_comb begin
      state_d = state_q;
      ptr_d   = ptr_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               ptr_d = '0;
               if (skip || !target_rw) state_d = ST_FINISH;
               else                    state_d = ST_WR_COMP;
            end
         end
         ST_WR_COMP: begin
            if (!at_first) begin
               state_d = ST_RD_PREV;
            end else if (at_last) begin
               state_d = ST_RD_LAST;
            end else begin
               ptr_d = ptr_q + ONE;
            end
         end
         ST_RD_PREV: state_d = ST_WR_TRUE;
         ST_WR_TRUE: begin
            if (at_last) begin
               state_d = ST_RD_LAST;
            end else begin
               ptr_d   = ptr_q + ONE;
               state_d = ST_WR_COMP;
            end
         end
         ST_RD_LAST: state_d = ST_DRAIN;
         ST_DRAIN:   state_d = ST_FINISH;
         ST_FINISH:  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
      end else begin
         state_q <= state_d;
         ptr_q   <= ptr_d;
      end
   end

   // Command decode
   always_comb begin
      op       = OP_NONE;
      cmd_addr = ptr_q;
      cmd_inv  = 1'b1;
      unique case (state_q)
         ST_WR_COMP: op = OP_WRITE;
         ST_RD_PREV: begin
            op       = OP_READ;
            cmd_addr = ptr_prev;
         end
         ST_WR_TRUE: begin
            op       = OP_WRITE;
            cmd_addr = ptr_prev;
            cmd_inv  = 1'b0;
         end
         ST_RD_LAST: op = OP_READ;
         default:    op = OP_NONE;
      endcase
   end

   assign cmd_en   = (op != OP_NONE);
   assign cmd_we   = (op == OP_WRITE);
   assign rd_issue = (op == OP_READ);
   assign clear    = (state_q == ST_IDLE) && start;
   assign busy     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
   assign done     = (state_q == ST_FINISH);

endmodule

// File: rtl/wcomp_check.sv
// Read-back comparator with one-cycle data alignment, saturating error
// counter and first-failure capture.
module wcomp_check #(
   parameter int AW = 4,
   parameter int DW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic          rd_issue,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_exp,
   input  logic [DW-1:0] rdata,
   output logic [CW-1:0] err_count,
   output logic          fail_valid,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_obs
);

   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   logic          pend_q;
   logic [AW-1:0] pend_addr_q;
   logic [DW-1:0] pend_exp_q;
   logic          mismatch;

   // Expected word travels alongside the RAM read latency
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
         pend_exp_q  <= '0;
      end else begin
         pend_q <= rd_issue;
         if (rd_issue) begin
            pend_addr_q <= rd_addr;
            pend_exp_q  <= rd_exp;
         end
      end
   end

   assign mismatch = pend_q && (rdata != pend_exp_q);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         err_count <= '0;
      end else if (mismatch && (err_count != CNT_MAX)) begin
         err_count <= err_count + CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         fail_valid <= 1'b0;
         fail_addr  <= '0;
         fail_exp   <= '0;
         fail_obs   <= '0;
      end else if (mismatch && !fail_valid) begin
         fail_valid <= 1'b1;
         fail_addr  <= pend_addr_q;
         fail_exp   <= pend_exp_q;
         fail_obs   <= rdata;
      end
   end

endmodule

// File: rtl/wcomp_bist.sv
// Walking complement self-test engine for a single-port synchronous RAM.
module wcomp_bist #(
   parameter int AW    = 4,
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   parameter int CW    = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          skip,
   input  logic          target_rw,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic [CW-1:0] err_count,
   output logic          fail_valid,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_obs
);

   // Elaboration-time parameter checks
   generate
      if (AW < 1) begin : g_bad_aw
         $error("wcomp_bist: AW must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("wcomp_bist: DW must be at least 1");
      end
      if (CW < 1) begin : g_bad_cw
         $error("wcomp_bist: CW must be at least 1");
      end
      if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("wcomp_bist: DEPTH must lie in 1 .. 2**AW");
      end
   endgenerate

   logic          cmd_inv;
   logic          rd_issue;
   logic          clear;
   logic [DW-1:0] inv_word;
   logic [DW-1:0] plain_word;

   wcomp_seq #(
      .AW    (AW),
      .DEPTH (DEPTH)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .skip      (skip),
      .target_rw (target_rw),
      .cmd_en    (mem_en),
      .cmd_we    (mem_we),
      .cmd_addr  (mem_addr),
      .cmd_inv   (cmd_inv),
      .rd_issue  (rd_issue),
      .clear     (clear),
      .busy      (busy),
      .done      (done)
   );

   wcomp_pattern #(
      .AW (AW),
      .DW (DW)
   ) u_pattern (
      .addr       (mem_addr),
      .inv_word   (inv_word),
      .plain_word (plain_word)
   );

   assign mem_wdata = cmd_inv ? inv_word : plain_word;

   wcomp_check #(
      .AW (AW),
      .DW (DW),
      .CW (CW)
   ) u_check (
      .clk        (clk),
      .rst        (rst),
      .clear      (clear),
      .rd_issue   (rd_issue),
      .rd_addr    (mem_addr),
      .rd_exp     (inv_word),
      .rdata      (mem_rdata),
      .err_count  (err_count),
      .fail_valid (fail_valid),
      .fail_addr  (fail_addr),
      .fail_exp   (fail_exp),
      .fail_obs   (fail_obs)
   );

   assign pass = (err_count == '0);

endmodule

// File: rtl/wcomp_bist_chk.sv
// Protocol checker attached to every wcomp_bist instance.
module wcomp_bist_chk #(
   parameter int AW    = 4,
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   parameter int CW    = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          skip,
   input logic          target_rw,
   input logic          mem_en,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          busy,
   input logic          done,
   input logic [CW-1:0] err_count,
   input logic          fail_valid,
   input logic [AW-1:0] fail_addr,
   input logic [DW-1:0] fail_exp,
   input logic [DW-1:0] fail_obs
);

   localparam logic [AW-1:0] TOP     = AW'(DEPTH - 1);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   logic idle;
   assign idle = !busy && !done;

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && !done && !mem_en && !fail_valid && err_count == '0));

   p_rd_after_wr_r2: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we) |-> $past(mem_en && mem_we));

   p_rewrite_follows_rd_r3: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we && mem_addr != TOP) |=>
         (mem_en && mem_we && mem_addr == $past(mem_addr)));

   p_no_back_to_back_rd_r4: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we) |=> !(mem_en && !mem_we));

   p_err_saturates_r6: assert property (@(posedge clk) disable iff (rst)
      (busy && err_count == CNT_MAX) |=> (err_count == CNT_MAX));

   p_err_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
      busy |=> (err_count >= $past(err_count)));

   p_first_fail_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(fail_valid) |-> (err_count == CW'(1)));

   p_fail_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (busy && fail_valid) |=>
         (fail_valid && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_obs)));

   p_skip_r8: assert property (@(posedge clk) disable iff (rst)
      (idle && start && (skip || !target_rw)) |=> (done && !busy && !mem_en));

   p_start_r9: assert property (@(posedge clk) disable iff (rst)
      (idle && start && !skip && target_rw) |=>
         (busy && mem_en && mem_we && mem_addr == '0));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !busy));

   p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !mem_en);

endmodule

bind wcomp_bist wcomp_bist_chk #(
   .AW    (AW),
   .DEPTH (DEPTH),
   .DW    (DW),
   .CW    (CW)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .skip       (skip),
   .target_rw  (target_rw),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .busy       (busy),
   .done       (done),
   .err_count  (err_count),
   .fail_valid (fail_valid),
   .fail_addr  (fail_addr),
   .fail_exp   (fail_exp),
   .fail_obs   (fail_obs)
);

// File: tb/wcomp_bist_bench.sv
`timescale 1ns/1ps
module wcomp_bist_bench;

   localparam int AW    = 4;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int CW    = 3;
   localparam int NOPS  = 3*DEPTH - 1;
   localparam int LOGN  = 64;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          skip = 1'b0;
   logic          target_rw = 1'b1;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, pass, fail_valid;
   logic [CW-1:0] err_count;
   logic [AW-1:0] fail_addr;
   logic [DW-1:0] fail_exp, fail_obs;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;  // 125 MHz

   wcomp_bist #(.AW(AW), .DEPTH(DEPTH), .DW(DW), .CW(CW)) u_wcomp_bist (
      .clk(clk), .rst(rst), .start(start), .skip(skip), .target_rw(target_rw),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .pass(pass), .err_count(err_count),
      .fail_valid(fail_valid), .fail_addr(fail_addr),
      .fail_exp(fail_exp), .fail_obs(fail_obs)
   );

   // RAM model: one-cycle read latency, read-side fault mask, access log
   logic [DW-1:0] ram   [DEPTH];
   logic [DW-1:0] fmask [DEPTH];
   logic          log_we   [LOGN];
   logic [AW-1:0] log_addr [LOGN];
   logic [DW-1:0] log_data [LOGN];
   int            op_cnt = 0;

   always @(posedge clk) begin
      if (mem_en) begin
         if (op_cnt < LOGN) begin
            log_we[op_cnt]   = mem_we;
            log_addr[op_cnt] = mem_addr;
            log_data[op_cnt] = mem_wdata;
         end
         op_cnt = op_cnt + 1;
         if (mem_we) ram[mem_addr] <= mem_wdata;
         else        mem_rdata     <= ram[mem_addr] ^ fmask[mem_addr];
      end
   end

   function automatic logic [DW-1:0] inv_of(int a);
      logic [DW-1:0] v;
      v = DW'(a);
      return ~v;
   endfunction

   function automatic logic [DW-1:0] plain_of(int a);
      return DW'(a);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_faults();
      for (int a = 0; a < DEPTH; a++) fmask[a] = '0;
   endtask

   task automatic fill_ram(input logic [DW-1:0] v);
      for (int a = 0; a < DEPTH; a++) ram[a] = v;
   endtask

   // Starts a walk and samples at falling edges until done
   task automatic run_walk(input bit sk, input bit rw, input int restart_at,
                           output int bcyc, output int dcyc);
      int  n;
      bit  fin;
      bcyc = 0; dcyc = 0; n = 0; fin = 0;
      @(negedge clk);
      op_cnt = 0;
      skip = sk; target_rw = rw; start = 1'b1;
      while (!fin) begin
         @(negedge clk);
         n++;
         start = (n == restart_at);
         if (busy) bcyc++;
         if (done) begin dcyc++; fin = 1; end
         if (n > 2000) begin
            fin = 1;
            check(1'b0, "R9", "walk timeout", n, 3*DEPTH+1);
         end
      end
      @(negedge clk);
      start = 1'b0;
      if (done) dcyc++;
      skip = 1'b0; target_rw = 1'b1;
   endtask

   // Compares the logged access stream with the expected walk order
   task automatic check_ops(input string req);
      int idx = 0;
      int bad = 0;
      for (int k = 0; k < DEPTH; k++) begin
         if (!(log_we[idx] && log_addr[idx] == AW'(k) && log_data[idx] == inv_of(k))) bad++;
         idx++;
         if (k > 0) begin
            if (!(!log_we[idx] && log_addr[idx] == AW'(k-1))) bad++;
            idx++;
            if (!(log_we[idx] && log_addr[idx] == AW'(k-1) && log_data[idx] == plain_of(k-1))) bad++;
            idx++;
         end
         if (k == DEPTH-1) begin
            if (!(!log_we[idx] && log_addr[idx] == AW'(k))) bad++;
            idx++;
         end
      end
      check(op_cnt == NOPS, req, "operation count", op_cnt, NOPS);
      check(bad == 0, req, "operation order/data mismatches", bad, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!busy && !done && !mem_en, "R1", "busy/done/mem_en after reset",
            {busy, done, mem_en}, 0);
      check(err_count == 0 && !fail_valid, "R1", "error state after reset",
            {fail_valid, err_count}, 0);
      check(pass, "R1", "pass after reset", pass, 1);
   endtask

   task automatic t_clean_walk();
      int b, d;
      clear_faults(); fill_ram(8'h5A);
      run_walk(0, 1, 0, b, d);
      check(b == 3*DEPTH, "R9", "busy cycles", b, 3*DEPTH);
      check(d == 1, "R9", "done pulse width", d, 1);
      check_ops("R2");
      for (int a = 0; a < DEPTH-1; a++)
         check(ram[a] == plain_of(a), "R3", "final contents below top", ram[a], plain_of(a));
      check(ram[DEPTH-1] == inv_of(DEPTH-1), "R5", "top location keeps inverse",
            ram[DEPTH-1], inv_of(DEPTH-1));
      check(err_count == 0 && pass && !fail_valid, "R4", "clean walk reports no error",
            err_count, 0);
   endtask

   task automatic t_single_fault();
      int b, d;
      clear_faults(); fmask[5] = 8'h01;
      run_walk(0, 1, 0, b, d);
      check(err_count == 1, "R4", "single fault count", err_count, 1);
      check(!pass, "R10", "pass low on failure", pass, 0);
      check(fail_valid && fail_addr == 4'd5, "R7", "fail address", fail_addr, 5);
      check(fail_exp == 8'hFA, "R7", "fail expected word", fail_exp, 8'hFA);
      check(fail_obs == 8'hFB, "R7", "fail observed word", fail_obs, 8'hFB);
   endtask

   task automatic t_two_faults();
      int b, d;
      clear_faults(); fmask[3] = 8'h10; fmask[9] = 8'h80;
      run_walk(0, 1, 0, b, d);
      check(err_count == 2, "R6", "two faults counted", err_count, 2);
      check(fail_addr == 4'd3 && fail_exp == 8'hFC && fail_obs == 8'hEC, "R7",
            "first failure kept", {fail_addr, fail_exp, fail_obs}, {4'd3, 8'hFC, 8'hEC});
   endtask

   task automatic t_top_fault();
      int b, d;
      clear_faults(); fmask[DEPTH-1] = 8'h04;
      run_walk(0, 1, 0, b, d);
      check(err_count == 1 && fail_addr == AW'(DEPTH-1), "R5", "top location read checked",
            {err_count, fail_addr}, {3'd1, 4'hF});
      check(fail_exp == 8'hF0 && fail_obs == 8'hF4, "R5", "top location words",
            {fail_exp, fail_obs}, {8'hF0, 8'hF4});
   endtask

   task automatic t_saturate();
      int b, d;
      clear_faults();
      for (int a = 0; a < DEPTH; a++) fmask[a] = 8'hFF;
      run_walk(0, 1, 0, b, d);
      check(err_count == 3'd7, "R6", "counter saturates", err_count, 7);
      check(b == 3*DEPTH, "R6", "walk continues after errors", b, 3*DEPTH);
      check(op_cnt == NOPS, "R6", "all operations issued despite errors", op_cnt, NOPS);
      check(fail_addr == 0 && fail_exp == 8'hFF && fail_obs == 8'h00, "R7",
            "first of many failures", {fail_addr, fail_exp, fail_obs}, {4'd0, 8'hFF, 8'h00});
   endtask

   task automatic t_skip();
      int b, d;
      clear_faults();
      run_walk(1, 1, 0, b, d);
      check(b == 0 && d == 1, "R8", "skip input: no busy, one done", {b, d}, 1);
      check(op_cnt == 0, "R8", "skip input: no accesses", op_cnt, 0);
      check(err_count == 0 && !fail_valid && pass, "R10", "start clears old error state",
            err_count, 0);
      run_walk(0, 0, 0, b, d);
      check(b == 0 && d == 1, "R8", "not read-write: no busy, one done", {b, d}, 1);
      check(op_cnt == 0, "R8", "not read-write: no accesses", op_cnt, 0);
   endtask

   task automatic t_restart_ignored();
      int b, d;
      clear_faults(); fill_ram(8'h00);
      run_walk(0, 1, 20, b, d);
      check(b == 3*DEPTH && d == 1, "R9", "start while busy ignored", b, 3*DEPTH);
      check_ops("R9");
   endtask

   task automatic t_reset_midwalk();
      clear_faults(); fmask[0] = 8'h01;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (9) @(negedge clk);
      check(busy && err_count == 1, "R11", "error recorded before reset", err_count, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!busy && !done && !mem_en, "R11", "idle after mid-walk reset",
            {busy, done, mem_en}, 0);
      check(err_count == 0 && !fail_valid, "R11", "error state cleared by reset",
            err_count, 0);
      repeat (3) @(negedge clk);
      check(!mem_en && !busy, "R11", "no traffic after reset", mem_en, 0);
   endtask

   initial begin
      clear_faults(); fill_ram('0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_clean_walk();
      t_single_fault();
      t_two_faults();
      t_top_fault();
      t_saturate();
      t_skip();
      t_restart_ignored();
      t_reset_midwalk();
      t_clean_walk();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(8 * 50000);
      n_checks++;
      n_errors++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule